// File: doc/BRIEF.md
# Three-C Cache Miss Classifier

This block is a passive monitor placed beside a small direct-mapped cache. It observes a stream of block addresses, one per cycle when qualified by a valid bit. Each access is sorted into one of four classes: a hit, a compulsory miss (the first reference to a block since reset), a capacity miss, or a conflict miss. A capacity miss is one that a fully associative cache of the same size would also suffer. A conflict miss is one that only the direct-mapped placement causes.

The block holds three structures to make that decision. The first is a tag model of the direct-mapped array. The second is a shadow fully associative cache with the same number of lines and true least-recently-used replacement. The third is a one-bit-per-block record of which addresses have been referenced. The class is registered and presented with a strobe. Four saturating counters accumulate the totals and can be cleared without touching any cache state. The line count, the address width and the counter width are parameters.

Top module: `three_c_classifier`

## Requirements
- R1: After reset, both cache models hold no valid line, no address is marked as referenced, `cls_valid_o` is 0 and all four counters read 0.
- R2: An access accepted at a rising edge (`acc_valid_i` high) yields `cls_valid_o` high with its class on `cls_o` right after that same edge. A cycle with no access leaves `cls_valid_o` low after the edge.
- R3: The code 00 (hit) is reported exactly when the direct-mapped model holds the address. A block that only the shadow cache holds never produces 00.
- R4: A miss on an address not referenced since reset is reported as 01 (compulsory), whatever either cache holds.
- R5: A miss on a previously referenced address that the shadow fully associative cache also lacks is reported as 10 (capacity).
- R6: A miss on a previously referenced address that the shadow cache still holds is reported as 11 (conflict).
- R7: The shadow cache refreshes recency on every access, hit or miss. When full, it evicts the least recently used entry on a miss.
- R8: The direct-mapped line index is the address modulo the line count, and the stored tag is the remaining upper address bits. Both models and the referenced-record take the current access only after its class is decided.
- R9: Each classified access adds one to the counter of its class. The counters are `cnt_hit_o`, `cnt_comp_o`, `cnt_cap_o` and `cnt_conf_o`. Each counter stops at 65535 (all ones for 16 bits).
- R10: `clr_i` high at a rising edge zeroes all four counters, overriding an increment in the same cycle, and leaves both cache models and the referenced-record unchanged.
- R11: With 4 lines, the stream 0,1,2,3,4,1,2,3,0,4,0 is classified as 01,01,01,01,01,00,00,00,10,10,11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W | Block address of the access |
| clr_i | input | 1 | Synchronous clear of the four counters |
| cls_valid_o | output | 1 | Class output valid |
| cls_o | output | 2 | Class: 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| cnt_hit_o | output | CNT_W | Hit count |
| cnt_comp_o | output | CNT_W | Compulsory miss count |
| cnt_cap_o | output | CNT_W | Capacity miss count |
| cnt_conf_o | output | CNT_W | Conflict miss count |

## Verification
The hardest case to reach from the ports is a miss whose class depends on LRU recency having been refreshed by a hit. An example is an address that survives in the shadow cache only because a direct-mapped hit made it most recent just before a new block filled the shadow cache. Directed short sequences build this state explicitly. A long pseudo-random stream over a window of four times the line count produces many mixed aliasing and eviction orders. A bench-side list model checks every class, and a long run of repeated hits drives a counter into saturation.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;
  typedef enum logic [1:0] {
    CLS_HIT  = 2'b00,
    CLS_COMP = 2'b01,
    CLS_CAP  = 2'b10,
    CLS_CONF = 2'b11
  } cls_e;
  localparam int NUM_CLS = 4;
endpackage

// File: rtl/tcc_dm_tags.sv
`timescale 1ns/1ps
module tcc_dm_tags #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign idx   = addr_i[IDX_W-1:0];
  assign tag   = addr_i[ADDR_W-1:IDX_W];
  assign hit_o = vld_q[idx] && (tag_q[idx] == tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (upd_i) begin
      vld_q[idx] <= 1'b1;
      tag_q[idx] <= tag;
    end
  end
endmodule

// File: rtl/tcc_fa_lru.sv
`timescale 1ns/1ps
module tcc_fa_lru #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int AGE_W = $clog2(LINES);
  localparam logic [AGE_W:0] OLDEST = (AGE_W+1)'(LINES - 1);
  localparam logic [AGE_W:0] NONE   = (AGE_W+1)'(LINES);

  logic [ADDR_W-1:0] tag_q [LINES];
  logic [AGE_W-1:0]  age_q [LINES];
  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  hit_vec;
  logic [AGE_W-1:0]  hit_idx, free_idx, old_idx, slot;
  logic              full;
  logic [AGE_W:0]    ref_age;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == addr_i);
    end
  endgenerate

  assign hit_o = |hit_vec;
  assign full  = &vld_q;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (hit_vec[i])                            hit_idx  = AGE_W'(i);
      if (!vld_q[i])                             free_idx = AGE_W'(i);
      if ({1'b0, age_q[i]} == OLDEST)            old_idx  = AGE_W'(i);
    end
    if (hit_o) begin
      slot    = hit_idx;
      ref_age = {1'b0, age_q[hit_idx]};
    end else if (full) begin
      slot    = old_idx;
      ref_age = OLDEST;
    end else begin
      slot    = free_idx;
      ref_age = NONE;  // fill: every valid entry ages
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else if (upd_i) begin
      for (int i = 0; i < LINES; i++) begin
        if (AGE_W'(i) == slot) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= addr_i;
          age_q[i] <= '0;
        end else if (vld_q[i] && ({1'b0, age_q[i]} < ref_age)) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tcc_seen_map.sv
`timescale 1ns/1ps
module tcc_seen_map #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              seen_o
);
  localparam int BLOCKS = 1 << ADDR_W;

  logic [BLOCKS-1:0] seen_q;

  assign seen_o = seen_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= '0;
    else if (upd_i) seen_q[addr_i] <= 1'b1;
  end
endmodule

// File: rtl/tcc_counters.sv
`timescale 1ns/1ps
module tcc_counters
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       inc_i,
  input  cls_e                       cls_i,
  input  logic                       clr_i,
  output logic [NUM_CLS-1:0][CNT_W-1:0] cnt_o
);
  genvar k;
  generate
    for (k = 0; k < NUM_CLS; k++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic             bump;
      assign bump     = inc_i && (cls_i == cls_e'(k)) && (cnt_q != '1);
      assign cnt_o[k] = cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (bump)  cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/three_c_classifier.sv
`timescale 1ns/1ps
module three_c_classifier
  import tcc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              clr_i,
  output logic              cls_valid_o,
  output logic [1:0]        cls_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_comp_o,
  output logic [CNT_W-1:0]  cnt_cap_o,
  output logic [CNT_W-1:0]  cnt_conf_o
);
  logic dm_hit, fa_hit, seen;
  cls_e cls_d, cls_q;
  logic vld_q;
  logic [NUM_CLS-1:0][CNT_W-1:0] cnt;

  tcc_dm_tags #(.LINES(LINES), .ADDR_W(ADDR_W)) u_dm (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(acc_valid_i),
    .addr_i(acc_addr_i), .hit_o(dm_hit)
  );

  tcc_fa_lru #(.LINES(LINES), .ADDR_W(ADDR_W)) u_fa (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(acc_valid_i),
    .addr_i(acc_addr_i), .hit_o(fa_hit)
  );

  tcc_seen_map #(.ADDR_W(ADDR_W)) u_seen (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(acc_valid_i),
    .addr_i(acc_addr_i), .seen_o(seen)
  );

  // direct-mapped hit dominates; shadow hit alone only splits misses
  always_comb begin
    if (dm_hit)      cls_d = CLS_HIT;
    else if (!seen)  cls_d = CLS_COMP;
    else if (fa_hit) cls_d = CLS_CONF;
    else             cls_d = CLS_CAP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cls_q <= CLS_HIT;
    end else begin
      vld_q <= acc_valid_i;
      if (acc_valid_i) cls_q <= cls_d;
    end
  end

  tcc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(acc_valid_i),
    .cls_i(cls_d), .clr_i(clr_i), .cnt_o(cnt)
  );

  assign cls_valid_o = vld_q;
  assign cls_o       = cls_q;
  assign cnt_hit_o   = cnt[0];
  assign cnt_comp_o  = cnt[1];
  assign cnt_cap_o   = cnt[2];
  assign cnt_conf_o  = cnt[3];
endmodule

// File: rtl/tcc_checker.sv
`timescale 1ns/1ps
module tcc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             clr_i,
  input logic             cls_valid_o,
  input logic [1:0]       cls_o,
  input logic [CNT_W-1:0] cnt_hit_o,
  input logic [CNT_W-1:0] cnt_comp_o,
  input logic [CNT_W-1:0] cnt_cap_o,
  input logic [CNT_W-1:0] cnt_conf_o
);
  logic             first_done_q;
  logic [CNT_W+1:0] sum;

  assign sum = {2'b00, cnt_hit_o} + {2'b00, cnt_comp_o}
             + {2'b00, cnt_cap_o} + {2'b00, cnt_conf_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          first_done_q <= 1'b0;
    else if (cls_valid_o) first_done_q <= 1'b1;
  end

  assert_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> cls_valid_o);

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !cls_valid_o);

  assert_first_comp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_valid_o && !first_done_q) |-> (cls_o == 2'b01));

  assert_no_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (sum >= $past(sum)));

  assert_one_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (sum <= $past(sum) + 1'b1));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum == '0));
endmodule

bind three_c_classifier tcc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .clr_i(clr_i),
  .cls_valid_o(cls_valid_o), .cls_o(cls_o),
  .cnt_hit_o(cnt_hit_o), .cnt_comp_o(cnt_comp_o),
  .cnt_cap_o(cnt_cap_o), .cnt_conf_o(cnt_conf_o)
);

// File: tb/sim_three_c_classifier.sv
`timescale 1ns/1ps
module sim_three_c_classifier;
  localparam int L  = 4;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int NB = 1 << AW;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          clr_in = 1'b0;
  logic          cls_valid;
  logic [1:0]    cls;
  logic [CW-1:0] c_hit, c_comp, c_cap, c_conf;

  three_c_classifier #(.LINES(L), .ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .clr_i(clr_in), .cls_valid_o(cls_valid), .cls_o(cls),
    .cnt_hit_o(c_hit), .cnt_comp_o(c_comp), .cnt_cap_o(c_cap), .cnt_conf_o(c_conf)
  );

  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  int dm_t [L];
  bit dm_v [L];
  int fa_q [L];   // index 0 = most recent
  int fa_n;
  bit seen [NB];
  int m_cnt [4];
  logic [1:0] last_cls;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'b00:   return "R3 hit";
      2'b01:   return "R4 compulsory";
      2'b10:   return "R5 capacity";
      default: return "R6 conflict";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < L; i++) begin dm_v[i] = 0; dm_t[i] = 0; fa_q[i] = -1; end
    for (int i = 0; i < NB; i++) seen[i] = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    fa_n = 0;
  endtask

  function automatic logic [1:0] predict(input int a);
    bit dmh, fah;
    dmh = dm_v[a % L] && (dm_t[a % L] == a / L);
    fah = 0;
    for (int j = 0; j < fa_n; j++) if (fa_q[j] == a) fah = 1;
    if (dmh)          return 2'b00;
    else if (!seen[a]) return 2'b01;
    else if (fah)     return 2'b11;
    else              return 2'b10;
  endfunction

  task automatic model_update(input int a);
    int pos;
    dm_v[a % L] = 1;
    dm_t[a % L] = a / L;
    seen[a] = 1;
    pos = -1;
    for (int j = 0; j < fa_n; j++) if (fa_q[j] == a) pos = j;
    if (pos < 0) begin
      if (fa_n < L) begin pos = fa_n; fa_n++; end
      else pos = L - 1;
    end
    for (int j = pos; j > 0; j--) fa_q[j] = fa_q[j-1];
    fa_q[0] = a;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_valid = 1'b0;
    clr_in = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_cnt(input string req);
    chk(c_hit  == CW'(m_cnt[0]), {req, " hit count"},  c_hit,  m_cnt[0]);
    chk(c_comp == CW'(m_cnt[1]), {req, " comp count"}, c_comp, m_cnt[1]);
    chk(c_cap  == CW'(m_cnt[2]), {req, " cap count"},  c_cap,  m_cnt[2]);
    chk(c_conf == CW'(m_cnt[3]), {req, " conf count"}, c_conf, m_cnt[3]);
  endtask

  task automatic acc(input int a, input bit clr);
    logic [1:0] e;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = AW'(a);
    clr_in    = clr;
    e = predict(a);
    model_update(a);
    if (clr) for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    else if (m_cnt[e] < CMAX) m_cnt[e]++;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    clr_in    = 1'b0;
    last_cls  = cls;
    chk(cls_valid == 1'b1, "R2 strobe", cls_valid, 1);
    chk(cls == e, req_of(e), cls, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] spec_exp [11];
    int         spec_seq [11];
    logic [15:0] lfsr;

    // R1: reset state
    do_reset();
    @(posedge clk); #1;
    chk(cls_valid == 1'b0, "R1 strobe after reset", cls_valid, 0);
    chk_cnt("R1");

    // R11: reference stream
    spec_seq = '{0, 1, 2, 3, 4, 1, 2, 3, 0, 4, 0};
    spec_exp = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00, 2'b00,
                 2'b10, 2'b10, 2'b11};
    for (int i = 0; i < 11; i++) begin
      acc(spec_seq[i], 1'b0);
      chk(last_cls == spec_exp[i], "R11 stream", last_cls, spec_exp[i]);
    end
    chk_cnt("R9");

    // R2: idle cycle drops the strobe
    @(posedge clk); #1;
    chk(cls_valid == 1'b0, "R2 idle", cls_valid, 0);

    // R8: 1 and 5 share line 1; shadow keeps both -> conflict, never hit (R3)
    do_reset();
    acc(1, 1'b0);
    acc(5, 1'b0);
    acc(1, 1'b0);
    chk(last_cls == 2'b11, "R8 alias conflict", last_cls, 3);
    acc(9, 1'b0);
    acc(9, 1'b0);
    chk(last_cls == 2'b00, "R8 same tag hit", last_cls, 0);

    // R7: hit on 0 refreshes recency, so 4 evicts 1 and 0 stays in shadow
    do_reset();
    for (int i = 0; i < 4; i++) acc(i, 1'b0);
    acc(0, 1'b0);
    acc(4, 1'b0);
    acc(0, 1'b0);
    chk(last_cls == 2'b11, "R7 recency on hit", last_cls, 3);
    acc(5, 1'b0);
    acc(1, 1'b0);
    chk(last_cls == 2'b10, "R7 LRU victim", last_cls, 2);

    // full sweep twice: first pass compulsory, second capacity
    do_reset();
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < NB; a++) acc(a, 1'b0);
    chk_cnt("R9 sweep");

    // pseudo-random window of 4*L addresses
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc(int'(lfsr[3:0]), 1'b0);
    end
    chk_cnt("R9 random");

    // R10: clear with a simultaneous access; state kept
    acc(7, 1'b1);
    chk_cnt("R10 clear");
    chk(c_hit == 0 && c_comp == 0 && c_cap == 0 && c_conf == 0,
        "R10 all zero", int'(c_hit) + int'(c_comp) + int'(c_cap) + int'(c_conf), 0);
    acc(7, 1'b0);
    chk(last_cls == 2'b00, "R10 cache kept", last_cls, 0);
    chk(c_hit == 1, "R10 count after clear", c_hit, 1);

    // R9: saturation
    do_reset();
    for (int i = 0; i < CMAX + 5; i++) acc(0, 1'b0);
    chk(c_hit == CW'(CMAX), "R9 saturate", c_hit, CMAX);
    chk(c_comp == 1, "R9 comp once", c_comp, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule